// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address for one access at a time. A request carries the virtual address, the kind of access (read, write, execute or a permission-free probe) and a privilege index from 0 (most privileged) to 3. The block first checks that the address is canonical. A negative address in the kernel window is mapped directly and needs no memory traffic. Any other address is resolved by walking three levels of 8-byte page table entries. The walk starts at a table base supplied on an input. Translations are not cached, so every walked request reads memory again.

The walk uses a single read port that allows one outstanding access. The block holds `mem_req` and `mem_addr` steady until memory answers with `mem_rvalid` and `mem_rdata`. The result appears as a single-cycle pulse on `resp_valid`, together with the physical address, the granted permission bits and a fault code. The controller moves through the states IDLE, READ_L1, READ_L2, READ_L3 and DONE:

- IDLE to DONE: taken when an accepted request is non-canonical or hits the kernel window.
- IDLE to READ_L1: taken for any other accepted request.
- READ_L1 to READ_L2 and READ_L2 to READ_L3: taken on an accepted, non-faulting entry.
- Any read state to DONE: taken on a fault, or on a good leaf entry at READ_L3.
- DONE to IDLE: taken unconditionally.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `resp_valid` and `mem_req` are 0.
- R2: The address is non-canonical when bits 63..43 are not all equal. Such an address yields fault code 1 (access violation) with no memory read, and the response comes in the cycle after acceptance.
- R3: An address with bit 63 set and bits 42..41 equal to 2'b10 is a window hit at privilege 0. It produces no memory read. The physical address is the address's bits 39..0, with its bit 40 placed at physical bit 43. The permission field is 3'b111 (bit 0 read, bit 1 write, bit 2 execute) and the fault code is 0. A negative address with any other value in bits 42..41 is walked.
- R4: A window hit at a privilege index other than 0 yields fault code 1.
- R5: Each level's table index is 10 bits, taken from the address at bit 33, then bit 23, then bit 13. Level k reads base + index*8, where the first base is `ptbr`. The next base is entry bits 63..32 shifted left by 13.
- R6: An entry whose bit 0 (valid) is clear yields fault code 2 (not valid) at any level, and the walk stops there.
- R7: At the first two levels, an entry with bit 8 (privileged read enable) clear yields fault code 1.
- R8: At the leaf, read and execute are granted by entry bit 8+p and write by entry bit 12+p, where p is the privilege index. If the needed right is not granted, the result is fault code 1. Access codes are 0 read, 1 write, 2 execute and 3 probe.
- R9: Leaf bits 1, 2 and 3 remove read, write and execute respectively. If this removes the needed right, the fault is 5 for execute, 4 for write and 3 for read, in that priority.
- R10: A good walk returns (leaf bits 63..32 << 13) | address bits 12..0, with the permissions left after R9 and fault code 0.
- R11: A probe needs no right, so it never faults at the leaf. It returns the permissions left after R9.
- R12: The block has at most one read outstanding. `mem_req` and `mem_addr` hold until `mem_rvalid`. `resp_valid` lasts exactly one cycle and `req_ready` is 1 the next cycle. The response follows the last accepted read by one cycle.
- R13: Whenever the fault code is not 0, the physical address and the permission field are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 probe |
| req_priv | input | 2 | Privilege index, 0 most privileged |
| ptbr | input | 64 | First-level table base, sampled at acceptance |
| req_ready | output | 1 | Block is idle and can take a request |
| mem_req | output | 1 | Table read request, held until answered |
| mem_addr | output | 64 | Address of the entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry returned by memory |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_pa | output | 64 | Physical address |
| resp_perm | output | 3 | Granted rights: bit 0 read, bit 1 write, bit 2 execute |
| resp_fault | output | 3 | 0 none, 1 access violation, 2 not valid, 3/4/5 fault-on read/write/execute |

## Verification
A wrong level or table base shows up at the ports on the very next read, as a `mem_addr` that differs from the entry address the model expects. A wrong state transition changes how many reads are issued, so the `resp_valid` pulse appears early, late or twice; this is caught in the first cycle it differs. A wrong rights or fault decision appears in the same cycle as the response, as a mismatch in the fault code, the permission bits or the address.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ_L1 = 3'd1,
        ST_READ_L2 = 3'd2,
        ST_READ_L3 = 3'd3,
        ST_DONE    = 3'd4
    } walk_state_e;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_ACV  = 3'd1,
        FLT_TNV  = 3'd2,
        FLT_FOR  = 3'd3,
        FLT_FOW  = 3'd4,
        FLT_FOE  = 3'd5
    } fault_e;

    // Entry field positions decoded by the walker.
    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_FO_LSB    = 1;
    localparam int PTE_RD_LSB    = 8;
    localparam int PTE_WR_LSB    = 12;
    localparam int PTE_PFN_LSB   = 32;

    localparam logic [1:0] ACC_PROBE = 2'd3;
    localparam logic [2:0] PERM_ALL  = 3'b111;

endpackage

// File: rtl/pw_va_classify.sv
module pw_va_classify #(
    parameter int VA_W    = 64,
    parameter int IMPL_VA = 43
) (
    input  logic [VA_W-1:0] va,
    output logic            canon_ok,
    output logic            window_hit,
    output logic [VA_W-1:0] window_pa
);
    localparam int SEG_LSB = IMPL_VA - 2;   // two-bit segment selector
    localparam int MOV_BIT = IMPL_VA - 3;   // bit relocated upward
    localparam int TOP_N   = VA_W - IMPL_VA;

    assign canon_ok   = (va[VA_W-1:IMPL_VA] == {TOP_N{va[VA_W-1]}});
    assign window_hit = va[VA_W-1] && (va[SEG_LSB +: 2] == 2'b10);

    always_comb begin
        window_pa                = '0;
        window_pa[MOV_BIT-1:0]   = va[MOV_BIT-1:0];
        window_pa[IMPL_VA]       = va[MOV_BIT];
    end
endmodule

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
    parameter int VA_W      = 64,
    parameter int PAGE_BITS = 13,
    parameter int IDX_BITS  = 10,
    parameter int LEVELS    = 3
) (
    input  logic [VA_W-1:0]  va,
    input  logic [VA_W-1:0]  base,
    input  logic [1:0]       level,
    output logic [VA_W-1:0]  addr
);
    localparam int ENTRY_SHIFT = 3;   // 8-byte entries

    logic [IDX_BITS-1:0] idx [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx[g] = va[PAGE_BITS + (LEVELS-1-g)*IDX_BITS +: IDX_BITS];
    end

    assign addr = base + (VA_W'(idx[level]) << ENTRY_SHIFT);
endmodule

// File: rtl/pw_pte_eval.sv
module pw_pte_eval
    import pt_walker_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PAGE_BITS = 13,
    parameter int PRIV_W    = 2
) (
    input  logic [63:0]       pte,
    input  logic              is_leaf,
    input  logic [PRIV_W-1:0] priv,
    input  logic [1:0]        acc,
    output fault_e            fault,
    output logic [2:0]        perm,
    output logic [VA_W-1:0]   frame
);
    localparam int NPRIV = 1 << PRIV_W;

    logic [NPRIV-1:0] rd_vec, wr_vec;
    logic [2:0]       need, granted, kept, fo;

    assign rd_vec  = pte[PTE_RD_LSB +: NPRIV];
    assign wr_vec  = pte[PTE_WR_LSB +: NPRIV];
    assign fo      = pte[PTE_FO_LSB +: 3];
    assign need    = (acc == ACC_PROBE) ? 3'b000 : (3'b001 << acc);
    assign granted = {rd_vec[priv], wr_vec[priv], rd_vec[priv]};
    assign kept    = granted & ~fo;
    assign frame   = VA_W'(pte[63:PTE_PFN_LSB]) << PAGE_BITS;

    always_comb begin
        fault = FLT_NONE;
        perm  = '0;
        if (!pte[PTE_VALID_BIT]) begin
            fault = FLT_TNV;
        end else if (!is_leaf) begin
            if (!pte[PTE_RD_LSB]) fault = FLT_ACV;
        end else if ((need != 3'b000) && ((granted & need) == 3'b000)) begin
            fault = FLT_ACV;
        end else if ((need != 3'b000) && ((kept & need) == 3'b000)) begin
            fault = need[2] ? FLT_FOE : (need[1] ? FLT_FOW : FLT_FOR);
        end else begin
            perm = kept;
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int IMPL_VA   = 43,
    parameter int PAGE_BITS = 13,
    parameter int IDX_BITS  = 10,
    parameter int PRIV_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [1:0]        req_acc,
    input  logic [PRIV_W-1:0] req_priv,
    input  logic [VA_W-1:0]   ptbr,
    output logic              req_ready,
    output logic              mem_req,
    output logic [VA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              resp_valid,
    output logic [VA_W-1:0]   resp_pa,
    output logic [2:0]        resp_perm,
    output logic [2:0]        resp_fault
);
    localparam logic [PRIV_W-1:0] KERNEL_PRIV = '0;

    walk_state_e       state_q, state_d;
    logic [VA_W-1:0]   va_q, base_q, base_d, pa_q, pa_d;
    logic [1:0]        acc_q;
    logic [PRIV_W-1:0] priv_q;
    logic [2:0]        perm_q, perm_d;
    fault_e            fault_q, fault_d;
    logic              load_req, base_en, res_en;
    logic [1:0]        level;

    logic              canon_ok, window_hit;
    logic [VA_W-1:0]   window_pa, entry_addr, ev_frame;
    fault_e            ev_fault;
    logic [2:0]        ev_perm;

    pw_va_classify #(.VA_W(VA_W), .IMPL_VA(IMPL_VA)) u_cls (
        .va(req_va), .canon_ok(canon_ok), .window_hit(window_hit), .window_pa(window_pa)
    );

    pw_entry_addr #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS), .LEVELS(3)) u_addr (
        .va(va_q), .base(base_q), .level(level), .addr(entry_addr)
    );

    pw_pte_eval #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PRIV_W(PRIV_W)) u_eval (
        .pte(mem_rdata), .is_leaf(state_q == ST_READ_L3), .priv(priv_q), .acc(acc_q),
        .fault(ev_fault), .perm(ev_perm), .frame(ev_frame)
    );

    // Next-state and capture decisions
    always_comb begin
        state_d  = state_q;
        load_req = 1'b0;
        base_en  = 1'b0;
        base_d   = base_q;
        res_en   = 1'b0;
        pa_d     = '0;
        perm_d   = '0;
        fault_d  = FLT_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    load_req = 1'b1;
                    if (!canon_ok) begin
                        state_d = ST_DONE;
                        res_en  = 1'b1;
                        fault_d = FLT_ACV;
                    end else if (window_hit) begin
                        state_d = ST_DONE;
                        res_en  = 1'b1;
                        if (req_priv != KERNEL_PRIV) begin
                            fault_d = FLT_ACV;
                        end else begin
                            pa_d   = window_pa;
                            perm_d = PERM_ALL;
                        end
                    end else begin
                        state_d = ST_READ_L1;
                        base_en = 1'b1;
                        base_d  = ptbr;
                    end
                end
            end
            ST_READ_L1, ST_READ_L2, ST_READ_L3: begin
                if (mem_rvalid) begin
                    if (ev_fault != FLT_NONE) begin
                        state_d = ST_DONE;
                        res_en  = 1'b1;
                        fault_d = ev_fault;
                    end else if (state_q == ST_READ_L3) begin
                        state_d = ST_DONE;
                        res_en  = 1'b1;
                        pa_d    = ev_frame | VA_W'(va_q[PAGE_BITS-1:0]);
                        perm_d  = ev_perm;
                    end else begin
                        base_en = 1'b1;
                        base_d  = ev_frame;
                        state_d = (state_q == ST_READ_L1) ? ST_READ_L2 : ST_READ_L3;
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request, base and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q    <= '0;
            acc_q   <= '0;
            priv_q  <= '0;
            base_q  <= '0;
            pa_q    <= '0;
            perm_q  <= '0;
            fault_q <= FLT_NONE;
        end else begin
            if (load_req) begin
                va_q   <= req_va;
                acc_q  <= req_acc;
                priv_q <= req_priv;
            end
            if (base_en) base_q <= base_d;
            if (res_en) begin
                pa_q    <= pa_d;
                perm_q  <= perm_d;
                fault_q <= fault_d;
            end
        end
    end

    // Outputs
    always_comb begin
        level = 2'd0;
        unique case (state_q)
            ST_READ_L2: level = 2'd1;
            ST_READ_L3: level = 2'd2;
            default:    level = 2'd0;
        endcase
        req_ready  = (state_q == ST_IDLE);
        mem_req    = (state_q == ST_READ_L1) || (state_q == ST_READ_L2) || (state_q == ST_READ_L3);
        mem_addr   = entry_addr;
        resp_valid = (state_q == ST_DONE);
        resp_pa    = pa_q;
        resp_perm  = perm_q;
        resp_fault = fault_q;
    end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int VA_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            mem_req,
    input logic [VA_W-1:0] mem_addr,
    input logic            mem_rvalid,
    input logic            resp_valid,
    input logic [VA_W-1:0] resp_pa,
    input logic [2:0]      resp_perm,
    input logic [2:0]      resp_fault
);
    assert_resp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_ready_after_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> req_ready);

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    assert_busy_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (!req_ready && !resp_valid));

    assert_fault_clean_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (resp_fault != 3'd0)) |-> ((resp_pa == '0) && (resp_perm == 3'd0)));

    assert_fault_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_fault <= 3'd5));
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .resp_valid(resp_valid),
    .resp_pa(resp_pa), .resp_perm(resp_perm), .resp_fault(resp_fault)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    localparam time CLK_P = 20ns;
    localparam logic [63:0] PTBR = 64'h0000_0000_0010_0000;
    localparam logic [15:0] V = 16'h0001, FR = 16'h0002, FW = 16'h0004, FE = 16'h0008;
    localparam logic [15:0] KR = 16'h0100, UR = 16'h0800, KW = 16'h1000, UW = 16'h8000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [1:0]  req_acc = '0, req_priv = '0;
    logic        req_ready, mem_req, mem_rvalid = 1'b0, resp_valid;
    logic [63:0] mem_addr, mem_rdata = '0, resp_pa;
    logic [2:0]  resp_perm, resp_fault;

    int total = 0, bad = 0, lat_cfg = 1, mcnt = 0;
    bit finished = 0;
    logic [63:0] pmem [logic [63:0]];
    logic [63:0] exp_q [$];

    always #(CLK_P/2) clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_acc(req_acc),
        .req_priv(req_priv), .ptbr(PTBR), .req_ready(req_ready), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_pa(resp_pa), .resp_perm(resp_perm), .resp_fault(resp_fault)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] rd(input logic [63:0] a);
        return pmem.exists(a) ? pmem[a] : 64'h0;
    endfunction

    function automatic logic [63:0] mk(input logic [31:0] pfn, input logic [15:0] fl);
        return {pfn, 16'h0, fl};
    endfunction

    // Memory responder: answers after lat_cfg cycles of a held request
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (rst_n && mem_req) begin
            mcnt++;
            if (mcnt >= lat_cfg) begin
                mcnt = 0;
                mem_rvalid = 1'b1;
                mem_rdata = rd(mem_addr);
                if (exp_q.size() == 0) chk(0, "R5 extra read", mem_addr, 64'h0);
                else begin
                    logic [63:0] ea;
                    ea = exp_q.pop_front();
                    chk(mem_addr == ea, "R5 entry address", mem_addr, ea);
                end
            end
        end
    end

    // Behavioural reference translation
    function automatic void ref_model(input logic [63:0] va, input logic [1:0] acc, input int pr,
                                      output logic [63:0] pa, output logic [2:0] perm,
                                      output logic [2:0] flt, output int nrd);
        logic signed [63:0] s;
        logic [63:0] base, e, a;
        logic [2:0] g, g2, need;
        pa = 0; perm = 0; flt = 0; nrd = 0; exp_q.delete();
        s = va;
        if ((s >>> 43) != (s >>> 63)) begin flt = 1; return; end
        if (va[63] && va[42:41] == 2'b10) begin
            if (pr != 0) begin flt = 1; return; end
            pa = (va & ((64'd1 << 40) - 1)) | ((va & (64'd1 << 40)) << 3);
            perm = 3'b111;
            return;
        end
        base = PTBR;
        for (int lv = 0; lv < 3; lv++) begin
            a = base + (((va >> (13 + 10*(2-lv))) & 64'h3ff) * 8);
            exp_q.push_back(a);
            e = rd(a);
            nrd++;
            if (!e[0]) begin flt = 2; return; end
            if (lv < 2) begin
                if (!e[8]) begin flt = 1; return; end
                base = (e >> 32) << 13;
            end
        end
        g = {e[8+pr], e[12+pr], e[8+pr]};
        need = (acc == 3) ? 3'b000 : (3'b001 << acc);
        if (need != 0 && (g & need) == 0) begin flt = 1; return; end
        g2 = g & ~3'((e >> 1) & 64'h7);
        if (need != 0 && (g2 & need) == 0) begin
            flt = (acc == 2) ? 3'd5 : (acc == 1) ? 3'd4 : 3'd3;
            return;
        end
        pa = ((e >> 32) << 13) | (va & 64'h1fff);
        perm = g2;
    endfunction

    task automatic mapva(input logic [63:0] va, input logic [63:0] p1, p2, p3);
        logic [63:0] b;
        pmem.delete();
        pmem[PTBR + 64'(va[42:33]) * 8] = p1;
        b = (p1 >> 32) << 13;
        pmem[b + 64'(va[32:23]) * 8] = p2;
        b = (p2 >> 32) << 13;
        pmem[b + 64'(va[22:13]) * 8] = p3;
    endtask

    task automatic run(input logic [63:0] va, input logic [1:0] acc, input int pr,
                       input int lat, input string tag);
        logic [63:0] epa; logic [2:0] eperm, eflt; int n;
        ref_model(va, acc, pr, epa, eperm, eflt, n);
        lat_cfg = lat;
        @(negedge clk);
        req_va = va; req_acc = acc; req_priv = 2'(pr); req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k <= n*lat; k++) begin
            if (k > 0) @(negedge clk);
            if (k < n*lat) chk(resp_valid == 1'b0, "R12 early response", 64'(resp_valid), 64'd0);
            else begin
                chk(resp_valid == 1'b1, "R12 response timing", 64'(resp_valid), 64'd1);
                chk(resp_fault == eflt, {tag, " fault"}, 64'(resp_fault), 64'(eflt));
                chk(resp_pa == epa, (eflt != 0) ? "R13 pa" : {tag, " pa"}, resp_pa, epa);
                chk(resp_perm == eperm, (eflt != 0) ? "R13 perm" : {tag, " perm"}, 64'(resp_perm), 64'(eperm));
            end
        end
        @(negedge clk);
        chk(!resp_valid && req_ready, "R12 pulse then ready", {62'd0, resp_valid, req_ready}, 64'd1);
        chk(exp_q.size() == 0, "R5 missing reads", 64'(exp_q.size()), 64'd0);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [63:0] va_a, va_n;
        va_a = 64'h0000_0123_4567_89AB;
        va_n = 64'hFFFF_FE12_3456_7ABC;
        repeat (3) @(negedge clk);
        chk(req_ready && !resp_valid && !mem_req, "R1 reset state",
            {61'd0, req_ready, resp_valid, mem_req}, 64'd4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !resp_valid && !mem_req, "R1 idle after reset",
            {61'd0, req_ready, resp_valid, mem_req}, 64'd4);

        // R2 non-canonical
        run(64'h0000_0800_0000_1000, 2'd0, 0, 1, "R2");
        run(64'hFFFF_F000_0000_0000, 2'd0, 0, 1, "R2");
        // R3 window, bit 40 set and clear; R4 non-kernel
        run(64'hFFFF_FD00_0012_3456, 2'd1, 0, 1, "R3");
        run(64'hFFFF_FC12_3456_789A, 2'd2, 0, 1, "R3");
        run(64'hFFFF_FD00_0012_3456, 2'd0, 1, 1, "R4");
        run(64'hFFFF_FC00_0000_0000, 2'd0, 3, 1, "R4");
        // R5/R10 good walks at several latencies
        mapva(va_a, mk(32'h200, V|KR), mk(32'h300, V|KR), mk(32'h4567, V|KR|KW));
        run(va_a, 2'd0, 0, 1, "R10");
        run(va_a, 2'd1, 0, 2, "R10");
        run(va_a, 2'd2, 0, 3, "R5");
        // R3 boundary: negative address with segment 11 is walked
        mapva(va_n, mk(32'h210, V|KR), mk(32'h310, V|KR), mk(32'h1ABCD, V|KR|KW));
        run(va_n, 2'd2, 0, 2, "R3");
        // R6 invalid at each level
        mapva(va_a, mk(32'h200, KR), mk(32'h300, V|KR), mk(32'h4567, V|KR));
        run(va_a, 2'd0, 0, 2, "R6");
        mapva(va_a, mk(32'h200, V|KR), mk(32'h300, KR), mk(32'h4567, V|KR));
        run(va_a, 2'd0, 0, 1, "R6");
        mapva(va_a, mk(32'h200, V|KR), mk(32'h300, V|KR), mk(32'h4567, KR|KW));
        run(va_a, 2'd0, 0, 2, "R6");
        // R7 missing privileged read at upper levels
        mapva(va_a, mk(32'h200, V), mk(32'h300, V|KR), mk(32'h4567, V|KR));
        run(va_a, 2'd0, 0, 1, "R7");
        mapva(va_a, mk(32'h200, V|KR), mk(32'h300, V), mk(32'h4567, V|KR));
        run(va_a, 2'd0, 0, 1, "R7");
        // R8 privilege-shifted rights
        mapva(va_a, mk(32'h200, V|KR), mk(32'h300, V|KR), mk(32'h7777, V|UR));
        run(va_a, 2'd0, 3, 1, "R8");
        run(va_a, 2'd1, 3, 1, "R8");
        run(va_a, 2'd0, 0, 1, "R8");
        mapva(va_a, mk(32'h200, V|KR), mk(32'h300, V|KR), mk(32'h7777, V|UR|UW));
        run(va_a, 2'd1, 3, 2, "R8");
        // R9 fault-on bits and priority
        mapva(va_a, mk(32'h200, V|KR), mk(32'h300, V|KR), mk(32'h5555, V|KR|KW|FR));
        run(va_a, 2'd0, 0, 1, "R9");
        run(va_a, 2'd1, 0, 1, "R9");
        mapva(va_a, mk(32'h200, V|KR), mk(32'h300, V|KR), mk(32'h5555, V|KR|KW|FW));
        run(va_a, 2'd1, 0, 1, "R9");
        mapva(va_a, mk(32'h200, V|KR), mk(32'h300, V|KR), mk(32'h5555, V|KR|KW|FE|FW|FR));
        run(va_a, 2'd2, 0, 1, "R9");
        // R11 probe never faults at the leaf
        run(va_a, 2'd3, 0, 2, "R11");
        mapva(va_a, mk(32'h200, V|KR), mk(32'h300, V|KR), mk(32'h5555, V|KR|FE));
        run(va_a, 2'd3, 0, 1, "R11");
        finish_up();
    end
endmodule